// File: doc/BRIEF.md
# Mirrored CPU Memory Bus Decoder

This block sits between an 8-bit processor and the devices in its address space. Each access presents a 16-bit address, a write byte and separate read and write strobes. The block decodes the address into one of three places. The low 8 KiB goes to a 2 KiB work RAM held inside the block, and that RAM repeats four times across the window. The next 8 KiB goes to an external port for eight peripheral registers, and those registers repeat every eight bytes. Every address above that is unmapped.

RAM writes land on the clock edge. RAM reads and peripheral reads return data combinationally in the same cycle. A synchronous reset starts a sweep that writes zero to every RAM byte, one byte per cycle. While the sweep runs, `busy` stays high and the block ignores all accesses. The processor must hold off until `busy` falls. This is the only back-pressure rule at the boundary: there is no per-access handshake, and any access presented while `busy` is high is dropped.

Top module: `membus_decoder`

## Requirements
- R1: After `rst` is released, `busy` is high for exactly 2048 cycles. It is high from the first cycle after reset. When it falls, every RAM byte reads 0x00.
- R2: A RAM write (`cpu_wr` high, address below 0x2000) updates the byte on that clock edge. A RAM read returns the stored byte on `cpu_rdata` in the same cycle it is presented.
- R3: Only address bits 10:0 index the RAM. Addresses 0x0000, 0x0800, 0x1000 and 0x1800, plus the same offsets from them, all reach one byte, for reads and for writes.
- R4: For addresses 0x2000 through 0x3FFF, `pp_sel` is high in the same cycle. `pp_idx` equals address bits 2:0, `pp_wr` follows `cpu_wr`, and `pp_wdata` carries `cpu_wdata`. A read in this window returns `pp_rdata` on `cpu_rdata`.
- R5: An access at 0x4000 or above raises `unmapped` for that cycle and returns 0x00 on `cpu_rdata`. A write there changes no RAM byte and does not raise `pp_sel`.
- R6: At most one target is selected in any cycle. With both strobes low, `pp_sel` and `unmapped` are low and `cpu_rdata` is 0x00.
- R7: While `busy` is high, accesses are ignored. `pp_sel` and `unmapped` stay low, `cpu_rdata` is 0x00, and writes do not land in RAM.
- R8: With both strobes high, the access counts as a write. `cpu_rdata` is 0x00 and the byte is stored.
- R9: A write in the peripheral window leaves the RAM byte at the same low 11 address bits unchanged. A RAM write does not raise `pp_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the RAM clear sweep |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data, same cycle |
| busy | output | 1 | High while the RAM clear sweep runs |
| unmapped | output | 1 | Access decoded to no target |
| pp_sel | output | 1 | Peripheral register port select |
| pp_wr | output | 1 | Peripheral access is a write |
| pp_idx | output | 3 | Peripheral register index |
| pp_wdata | output | 8 | Peripheral write byte |
| pp_rdata | input | 8 | Peripheral read byte |

## Verification
Two kinds of wrong internal state can occur. If the clear counter is stuck or miscounted, `busy` falls at the wrong cycle, or a later read of some RAM byte returns a nonzero value. This shows within 2048 cycles of reset, or on the first read of an uncleared byte. If the address mask is wrong, a byte written through one alias reads back differently through another alias. This shows on the cycle after the write. A decode fault shows in the same cycle as the access: `pp_sel`, `unmapped` or the `pp_rdata` pass-through is wrong.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_PORT = 2'd2,
    TGT_VOID = 2'd3
  } tgt_e;
endpackage

// File: rtl/mb_addr_decode.sv
module mb_addr_decode
  import membus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_AW = 13
) (
  input  logic [ADDR_W-WIN_AW-1:0] win_bits,
  input  logic                     rd,
  input  logic                     wr,
  input  logic                     blocked,
  output tgt_e                     tgt,
  output logic                     rd_only
);
  localparam int WB = ADDR_W - WIN_AW;
  localparam logic [WB-1:0] WIN_RAM  = '0;
  localparam logic [WB-1:0] WIN_PORT = WB'(1);

  logic active;
  assign active  = (rd | wr) & ~blocked;
  assign rd_only = rd & ~wr;

  always_comb begin
    if (!active)                tgt = TGT_NONE;
    else if (win_bits == WIN_RAM)  tgt = TGT_RAM;
    else if (win_bits == WIN_PORT) tgt = TGT_PORT;
    else                        tgt = TGT_VOID;
  end
endmodule

// File: rtl/mb_work_ram.sv
module mb_work_ram #(
  parameter int DATA_W = 8,
  parameter int RAM_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RAM_AW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [RAM_AW-1:0] clr_ptr;
  logic              clr_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_ptr <= '0;
      clr_on  <= 1'b1;
    end else if (clr_on) begin
      clr_ptr <= clr_ptr + 1'b1;
      if (&clr_ptr) clr_on <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_on)  mem[clr_ptr] <= '0;
    else if (we) mem[idx]     <= wdata;
  end

  assign rdata = mem[idx];
  assign busy  = clr_on;
endmodule

// File: rtl/mb_periph_port.sv
module mb_periph_port #(
  parameter int DATA_W = 8,
  parameter int REG_AW = 3
) (
  input  logic              hit,
  input  logic              wr,
  input  logic [REG_AW-1:0] idx_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              sel,
  output logic              sel_wr,
  output logic [REG_AW-1:0] idx,
  output logic [DATA_W-1:0] wdata
);
  assign sel    = hit;
  assign sel_wr = hit & wr;
  assign idx    = hit ? idx_in   : '0;
  assign wdata  = hit ? wdata_in : '0;
endmodule

// File: rtl/membus_decoder.sv
module membus_decoder
  import membus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 11,
  parameter int WIN_AW = 13,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              busy,
  output logic              unmapped,
  output logic              pp_sel,
  output logic              pp_wr,
  output logic [REG_AW-1:0] pp_idx,
  output logic [DATA_W-1:0] pp_wdata,
  input  logic [DATA_W-1:0] pp_rdata
);
  tgt_e              tgt;
  logic              rd_only;
  logic              ram_hit;
  logic [DATA_W-1:0] ram_q;

  mb_addr_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) u_dec (
    .win_bits (cpu_addr[ADDR_W-1:WIN_AW]),
    .rd       (cpu_rd),
    .wr       (cpu_wr),
    .blocked  (busy),
    .tgt      (tgt),
    .rd_only  (rd_only)
  );

  assign ram_hit  = (tgt == TGT_RAM);
  assign unmapped = (tgt == TGT_VOID);

  mb_work_ram #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (ram_hit & cpu_wr),
    .idx   (cpu_addr[RAM_AW-1:0]),
    .wdata (cpu_wdata),
    .rdata (ram_q),
    .busy  (busy)
  );

  mb_periph_port #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_port (
    .hit      (tgt == TGT_PORT),
    .wr       (cpu_wr),
    .idx_in   (cpu_addr[REG_AW-1:0]),
    .wdata_in (cpu_wdata),
    .sel      (pp_sel),
    .sel_wr   (pp_wr),
    .idx      (pp_idx),
    .wdata    (pp_wdata)
  );

  always_comb begin
    cpu_rdata = '0;
    if (rd_only) begin
      unique case (tgt)
        TGT_RAM:  cpu_rdata = ram_q;
        TGT_PORT: cpu_rdata = pp_rdata;
        default:  cpu_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/membus_decoder_chk.sv
module membus_decoder_chk #(
  parameter int DEPTH = 2048
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_rdata,
  input logic [7:0]  pp_rdata,
  input logic        pp_sel,
  input logic        unmapped,
  input logic        ram_hit
);
  localparam int CW = $clog2(DEPTH) + 1;
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != CW'(DEPTH)) since_rst <= since_rst + 1'b1;
  end

  assert_busy_window_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CW'(DEPTH)) |-> busy);
  assert_busy_done_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == CW'(DEPTH)) |-> !busy);
  assert_port_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && cpu_rd && !cpu_wr && cpu_addr >= 16'h2000 && cpu_addr < 16'h4000)
      |-> (pp_sel && cpu_rdata == pp_rdata));
  assert_void_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && (cpu_rd || cpu_wr) && cpu_addr >= 16'h4000)
      |-> (unmapped && !pp_sel && cpu_rdata == 8'h00));
  assert_one_target_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_hit, pp_sel, unmapped}));
  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |-> (!pp_sel && !unmapped && !ram_hit && cpu_rdata == 8'h00));
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!pp_sel && !unmapped && !ram_hit && cpu_rdata == 8'h00));
  assert_both_strobes_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_wr) |-> (cpu_rdata == 8'h00));
endmodule

bind membus_decoder membus_decoder_chk #(.DEPTH(1 << RAM_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_addr  (cpu_addr),
  .cpu_rdata (cpu_rdata),
  .pp_rdata  (pp_rdata),
  .pp_sel    (pp_sel),
  .unmapped  (unmapped),
  .ram_hit   (ram_hit)
);

// File: tb/sim_membus_decoder.sv
`timescale 1ns/1ps
module sim_membus_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata, pp_wdata, pp_rdata;
  logic        busy, unmapped, pp_sel, pp_wr;
  logic [2:0]  pp_idx;

  always #2.5 clk = ~clk;

  // external register file model: register n reads back 0xA0 | n
  assign pp_rdata = 8'hA0 | {5'b0, pp_idx};

  membus_decoder u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .busy(busy),
    .unmapped(unmapped), .pp_sel(pp_sel), .pp_wr(pp_wr), .pp_idx(pp_idx),
    .pp_wdata(pp_wdata), .pp_rdata(pp_rdata)
  );

  typedef struct {
    logic [7:0] rdata;
    logic       unm;
    logic       sel;
    logic       wr;
    logic [2:0] idx;
    logic [7:0] wdata;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_errs   = 0;
  bit   done     = 0;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // monitor: compares each expected item in the cycle it was driven
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(cpu_rdata == e.rdata, {e.tag, " rdata"}, $sformatf("%02h", cpu_rdata), $sformatf("%02h", e.rdata));
      check(unmapped == e.unm, {e.tag, " unmapped"}, $sformatf("%0b", unmapped), $sformatf("%0b", e.unm));
      check(pp_sel == e.sel, {e.tag, " pp_sel"}, $sformatf("%0b", pp_sel), $sformatf("%0b", e.sel));
      if (e.sel) begin
        check(pp_idx == e.idx && pp_wr == e.wr && (!e.wr || pp_wdata == e.wdata), {e.tag, " port"},
              $sformatf("idx=%0d wr=%0b wd=%02h", pp_idx, pp_wr, pp_wdata),
              $sformatf("idx=%0d wr=%0b wd=%02h", e.idx, e.wr, e.wdata));
      end
    end
  end

  // driver: drives one access at a negedge and queues its expectation
  task automatic access(input bit rd, input bit wr, input logic [15:0] a, input logic [7:0] wd,
                        input logic [7:0] x_rd, input bit x_unm, input bit x_sel, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
    e.rdata = x_rd; e.unm = x_unm; e.sel = x_sel; e.wr = wr;
    e.idx = a[2:0]; e.wdata = wd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic run_reset(input bool_poke);
    int cnt;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(busy === 1'b1, "R1 busy after reset", $sformatf("%0b", busy), "1");
    cnt = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (bool_poke && i == 10) begin cpu_wr = 1; cpu_addr = 16'h0005; cpu_wdata = 8'h77; end
      else if (bool_poke && i == 11) begin cpu_wr = 0; cpu_rd = 1; cpu_addr = 16'h4100; end
      else if (bool_poke && i == 12) begin cpu_rd = 1; cpu_addr = 16'h2003; end
      else begin cpu_rd = 0; cpu_wr = 0; end
      #1;
      if (bool_poke && i >= 10 && i <= 12)
        check(cpu_rdata == 0 && !unmapped && !pp_sel, "R7 access while busy",
              $sformatf("rd=%02h unm=%0b sel=%0b", cpu_rdata, unmapped, pp_sel), "rd=00 unm=0 sel=0");
      if (busy) cnt++;
      else break;
    end
    check(cnt == 2048, "R1 busy length", $sformatf("%0d", cnt), "2048");
  endtask

  initial begin
    cpu_rd = 0; cpu_wr = 0;
    run_reset(1'b1);

    access(1, 0, 16'h0005, 0, 8'h00, 0, 0, "R7 busy write dropped");
    access(1, 0, 16'h07FF, 0, 8'h00, 0, 0, "R1 cleared byte");
    access(1, 0, 16'h0400, 0, 8'h00, 0, 0, "R1 cleared byte mid");

    access(0, 1, 16'h0123, 8'h5A, 8'h00, 0, 0, "R2 ram write");
    access(1, 0, 16'h0123, 0, 8'h5A, 0, 0, "R2 readback same cycle");
    access(1, 0, 16'h0923, 0, 8'h5A, 0, 0, "R3 alias 0x0800");
    access(1, 0, 16'h1123, 0, 8'h5A, 0, 0, "R3 alias 0x1000");
    access(1, 0, 16'h1923, 0, 8'h5A, 0, 0, "R3 alias 0x1800");
    access(0, 1, 16'h1FFF, 8'hC3, 8'h00, 0, 0, "R3 write via top alias");
    access(1, 0, 16'h07FF, 0, 8'hC3, 0, 0, "R3 base sees alias write");

    access(1, 0, 16'h2000, 0, 8'hA0, 0, 1, "R4 port reg0");
    access(1, 0, 16'h3FFD, 0, 8'hA5, 0, 1, "R4 port reg5 mirror");
    access(0, 1, 16'h2A0B, 8'h99, 8'h00, 0, 1, "R4 port write idx3");
    access(1, 0, 16'h020B, 0, 8'h00, 0, 0, "R9 port write spared ram");

    access(1, 0, 16'h4000, 0, 8'h00, 1, 0, "R5 unmapped read");
    access(0, 1, 16'h4000, 8'h55, 8'h00, 1, 0, "R5 unmapped write");
    access(0, 1, 16'hFFFF, 8'hEE, 8'h00, 1, 0, "R5 top unmapped write");
    access(1, 0, 16'h0000, 0, 8'h00, 0, 0, "R5 ram untouched at 0");
    access(1, 0, 16'h07FF, 0, 8'hC3, 0, 0, "R5 ram untouched at 7FF");

    access(0, 0, 16'h0123, 0, 8'h00, 0, 0, "R6 idle ram addr");
    access(0, 0, 16'h2001, 0, 8'h00, 0, 0, "R6 idle port addr");

    access(1, 1, 16'h0300, 8'h3C, 8'h00, 0, 0, "R8 both strobes");
    access(1, 0, 16'h0300, 0, 8'h3C, 0, 0, "R8 byte stored");
    access(1, 1, 16'h2006, 8'h42, 8'h00, 0, 1, "R8 both strobes port");
    idle();

    run_reset(1'b0);
    access(1, 0, 16'h0123, 0, 8'h00, 0, 0, "R1 cleared after second reset");
    access(1, 0, 16'h1B00, 0, 8'h00, 0, 0, "R1 cleared alias 0x0300");
    idle();
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_errs++; n_checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule